// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative address translation buffer. Each slot maps one pair of adjacent virtual pages to two physical frames, one for the even page and one for the odd page. Every slot has its own page-size mask, an address-space identifier and a global flag. A lookup takes a virtual address, the requester's address-space identifier, the access size in bytes, the access kind (fetch, load or store) and the processor status word. One clock later the block returns a physical address, an uncacheable flag and a fault code.

A processor core uses it on the address path of its load/store and fetch units. Software fills slots through an indexed write port. An associative probe port returns the slot that matches a page number. A flush input empties the whole buffer and returns the replacement pointer to slot zero. Two kernel address windows bypass translation and map straight onto physical space. One of them is open only when the status word says the processor is in kernel mode.

Top module: `paired_tlb`

## Requirements
- R1: A slot matches when it has been written since the last flush or reset, its page number equals the lookup page number on every bit its mask leaves clear, and either its global flag is set or its identifier equals the requester's. When several slots match, the lowest-numbered slot is used.
- R2: The lookup page number is vaddr[31:11]. Its two low bits are forced to zero unless `small_pages` is 1.
- R3: A slot's page shift is 10 plus the number of ones in its mask. vaddr bit [shift] picks the half: 0 selects the even frame with its valid and dirty bits, and 1 selects the odd frame with its own bits.
- R4: On a translated hit, paddr = ((frame << 12) >> shift) << shift, ORed with the vaddr bits below the shift.
- R5: Fault codes are 0 none, 1 address error, 2 refill, 3 invalid and 4 modified. No matching slot gives 2. A matching slot whose selected half has its valid bit clear gives 3. A store (kind 2) to a valid half whose dirty bit is clear gives 4. `rs_write` is 1 exactly when the access kind is store (fetch 0, load 1, store 2). `rs_paddr` is 0 whenever the fault code is not 0.
- R6: If vaddr & (size − 1) is non-zero, the result is fault 1. This check takes priority over every other outcome.
- R7: vaddr[31:29] = 3'b100 (cached kernel window) and 3'b101 (uncached kernel window) bypass the slots and give paddr = vaddr & 0x1FFFFFFF. In the cached window, a processor that is not in kernel mode gets fault 1.
- R8: The processor is in kernel mode when any status bit in 0x10000006 is set, or when status[4:3] is 0. The value 1 in that field means supervisor and 2 means user; neither of these is kernel mode.
- R9: `rs_uncached` is 1 exactly when vaddr bits 31 and 29 are both set, whatever the fault.
- R10: A write takes effect at the clock edge and is seen by a lookup in the next cycle. A write to an index of 16 or more changes no slot.
- R11: `flush` empties every slot and sets `victim_idx` to 0. Flush wins over a write or an advance in the same cycle. Each `victim_adv` cycle moves `victim_idx` up by one and wraps from 15 to 0.
- R12: A probe returns `pr_hit`=1 with the lowest matching slot number under the R1 rule applied to `pr_vpn` as given, or `pr_hit`=0 if no slot matches. The result appears one cycle after `pr_en`.
- R13: Reset clears `rs_valid`, `rs_fault`, `pr_done` and `victim_idx` and empties every slot. `rs_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Requester address-space identifier |
| lk_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_status | input | 32 | Processor status word |
| small_pages | input | 1 | Keeps the two low page-number bits |
| rs_valid | output | 1 | Result valid |
| rs_paddr | output | 32 | Physical address |
| rs_uncached | output | 1 | Uncacheable access |
| rs_fault | output | 3 | Fault code |
| rs_write | output | 1 | Access was a store |
| wr_en | input | 1 | Slot write strobe |
| wr_index | input | 5 | Slot number to write |
| wr_vpn | input | 21 | Slot page number |
| wr_mask | input | 21 | Slot page-size mask |
| wr_asid | input | 8 | Slot identifier |
| wr_global | input | 1 | Slot matches any identifier |
| wr_pfn_even | input | 20 | Even-half frame number |
| wr_valid_even | input | 1 | Even-half valid |
| wr_dirty_even | input | 1 | Even-half writable |
| wr_pfn_odd | input | 20 | Odd-half frame number |
| wr_valid_odd | input | 1 | Odd-half valid |
| wr_dirty_odd | input | 1 | Odd-half writable |
| pr_en | input | 1 | Probe request |
| pr_vpn | input | 21 | Probe page number |
| pr_asid | input | 8 | Probe identifier |
| pr_done | output | 1 | Probe result valid |
| pr_hit | output | 1 | Probe found a slot |
| pr_index | output | 4 | Matching slot number |
| flush | input | 1 | Empty all slots |
| victim_adv | input | 1 | Advance replacement pointer |
| victim_idx | output | 4 | Replacement pointer |

## Verification
The hardest outcomes to reach are the ones that need two things to be true at once. A page must match under its mask while the address bit at that slot's own shift points to a half whose valid or dirty bit is clear. The same page number must sit in two slots so that only the priority rule decides the result. The stimulus loads slots with masks of 0, 3 and 15, one duplicated page, one half-invalid pair and one read-only half. It then sweeps addresses on both sides of each pair boundary across every access kind, size, identifier, status pattern and page-size mode. Each result is compared against an arithmetic model of the translation rules.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ADDR     = 3'd1,
    FLT_REFILL   = 3'd2,
    FLT_INVALID  = 3'd3,
    FLT_MODIFIED = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_UNDEF  = 2'd3
  } priv_e;

  localparam int STATUS_W = 32;
endpackage

// File: rtl/ptlb_priv.sv
module ptlb_priv
  import ptlb_pkg::*;
(
  input  logic [STATUS_W-1:0] status,
  output priv_e               priv
);
  logic force_kernel;
  logic unused_status_bits;

  assign force_kernel       = status[28] | status[2] | status[1];
  assign unused_status_bits = ^{status[31:29], status[27:5], status[0]};

  always_comb begin
    if (force_kernel || status[4:3] == 2'd0) priv = PRIV_KERNEL;
    else if (status[4:3] == 2'd1)            priv = PRIV_SUPER;
    else if (status[4:3] == 2'd2)            priv = PRIV_USER;
    else                                     priv = PRIV_UNDEF;
  end
endmodule

// File: rtl/ptlb_tag_cmp.sv
module ptlb_tag_cmp #(
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8
) (
  input  logic              live,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [VPN_W-1:0]  e_mask,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_global,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit
);
  logic page_eq;
  logic space_eq;

  assign page_eq  = ((q_vpn ^ e_vpn) & ~e_mask) == '0;
  assign space_eq = e_global | (q_asid == e_asid);
  assign hit      = live & page_eq & space_eq;
endmodule

// File: rtl/ptlb_first.sv
module ptlb_first #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R1: the reported slot really requested
  p_first_is_request_r1: assert property (@(posedge clk) disable iff (rst)
    found |-> req[idx]);
  // R1: nothing reported when nothing requested
  p_first_none_r1: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> !found);
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import ptlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ASID_W    = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic [3:0]               lk_size,
  input  logic [1:0]               lk_kind,
  input  logic [31:0]              lk_status,
  input  logic                     small_pages,
  output logic                     rs_valid,
  output logic [PA_W-1:0]          rs_paddr,
  output logic                     rs_uncached,
  output logic [2:0]               rs_fault,
  output logic                     rs_write,
  input  logic                     wr_en,
  input  logic [$clog2(N_ENTRIES):0] wr_index,
  input  logic [VA_W-12:0]         wr_vpn,
  input  logic [VA_W-12:0]         wr_mask,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic                     wr_global,
  input  logic [PA_W-13:0]         wr_pfn_even,
  input  logic                     wr_valid_even,
  input  logic                     wr_dirty_even,
  input  logic [PA_W-13:0]         wr_pfn_odd,
  input  logic                     wr_valid_odd,
  input  logic                     wr_dirty_odd,
  input  logic                     pr_en,
  input  logic [VA_W-12:0]         pr_vpn,
  input  logic [ASID_W-1:0]        pr_asid,
  output logic                     pr_done,
  output logic                     pr_hit,
  output logic [$clog2(N_ENTRIES)-1:0] pr_index,
  input  logic                     flush,
  input  logic                     victim_adv,
  output logic [$clog2(N_ENTRIES)-1:0] victim_idx
);
  localparam int IDX_W  = $clog2(N_ENTRIES);
  localparam int WIDX_W = IDX_W + 1;
  localparam int VPN_W  = VA_W - 11;
  localparam int PFN_W  = PA_W - 12;
  localparam int SH_W   = $clog2(VA_W);
  localparam logic [WIDX_W-1:0] N_W    = WIDX_W'(N_ENTRIES);
  localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(N_ENTRIES - 1);

  // slot storage: occupancy flops with reset, payload without
  logic [N_ENTRIES-1:0] occ;
  logic [VPN_W-1:0]  e_vpn   [N_ENTRIES];
  logic [VPN_W-1:0]  e_mask  [N_ENTRIES];
  logic [ASID_W-1:0] e_asid  [N_ENTRIES];
  logic              e_g     [N_ENTRIES];
  logic [PFN_W-1:0]  e_pfn0  [N_ENTRIES];
  logic [PFN_W-1:0]  e_pfn1  [N_ENTRIES];
  logic              e_v0    [N_ENTRIES];
  logic              e_v1    [N_ENTRIES];
  logic              e_d0    [N_ENTRIES];
  logic              e_d1    [N_ENTRIES];
  logic [SH_W-1:0]   e_shift [N_ENTRIES];

  logic              wr_in_range;
  logic [IDX_W-1:0]  wr_slot;
  logic [IDX_W-1:0]  victim_q;

  assign wr_in_range = wr_index < N_W;
  assign wr_slot     = wr_index[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ      <= '0;
      victim_q <= '0;
    end else begin
      if (wr_en && wr_in_range) occ[wr_slot] <= 1'b1;
      if (victim_adv) victim_q <= (victim_q == LAST_I) ? '0 : victim_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      e_vpn[wr_slot]   <= wr_vpn;
      e_mask[wr_slot]  <= wr_mask;
      e_asid[wr_slot]  <= wr_asid;
      e_g[wr_slot]     <= wr_global;
      e_pfn0[wr_slot]  <= wr_pfn_even;
      e_pfn1[wr_slot]  <= wr_pfn_odd;
      e_v0[wr_slot]    <= wr_valid_even;
      e_v1[wr_slot]    <= wr_valid_odd;
      e_d0[wr_slot]    <= wr_dirty_even;
      e_d1[wr_slot]    <= wr_dirty_odd;
      e_shift[wr_slot] <= SH_W'(10 + $countones(wr_mask));
    end
  end

  assign victim_idx = victim_q;

  // lookup page number
  logic [VPN_W-1:0] q_vpn;
  always_comb begin
    q_vpn = lk_vaddr[VA_W-1:11];
    if (!small_pages) q_vpn[1:0] = 2'b00;
  end

  // two comparator banks: lookup and probe
  logic [N_ENTRIES-1:0] lk_req;
  logic [N_ENTRIES-1:0] pb_req;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    ptlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
      .live(occ[g]), .e_vpn(e_vpn[g]), .e_mask(e_mask[g]), .e_asid(e_asid[g]),
      .e_global(e_g[g]), .q_vpn(q_vpn), .q_asid(lk_asid), .hit(lk_req[g]));
    ptlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_pb_cmp (
      .live(occ[g]), .e_vpn(e_vpn[g]), .e_mask(e_mask[g]), .e_asid(e_asid[g]),
      .e_global(e_g[g]), .q_vpn(pr_vpn), .q_asid(pr_asid), .hit(pb_req[g]));
  end

  logic             lk_found;
  logic [IDX_W-1:0] lk_idx;
  logic             pb_found;
  logic [IDX_W-1:0] pb_idx;

  ptlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_lk_first (
    .clk(clk), .rst(rst), .req(lk_req), .found(lk_found), .idx(lk_idx));
  ptlb_first #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pb_first (
    .clk(clk), .rst(rst), .req(pb_req), .found(pb_found), .idx(pb_idx));

  priv_e priv;
  ptlb_priv u_priv (.status(lk_status), .priv(priv));

  // half selection and address formation
  logic [SH_W-1:0]  sel_sh;
  logic             sel_odd;
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_v;
  logic             sel_d;
  logic [VA_W-1:0]  off_mask;
  logic [PA_W-1:0]  frame_base;
  logic [PA_W-1:0]  pa_mapped;
  logic [PA_W-1:0]  pa_direct;

  assign sel_sh     = e_shift[lk_idx];
  assign sel_odd    = lk_vaddr[sel_sh];
  assign sel_pfn    = sel_odd ? e_pfn1[lk_idx] : e_pfn0[lk_idx];
  assign sel_v      = sel_odd ? e_v1[lk_idx]   : e_v0[lk_idx];
  assign sel_d      = sel_odd ? e_d1[lk_idx]   : e_d0[lk_idx];
  assign off_mask   = (VA_W'(1) << sel_sh) - VA_W'(1);
  assign frame_base = (({sel_pfn, 12'h000}) >> sel_sh) << sel_sh;
  assign pa_mapped  = frame_base | PA_W'(lk_vaddr & off_mask);
  assign pa_direct  = PA_W'({3'b000, lk_vaddr[VA_W-4:0]});

  logic       misaligned;
  logic [2:0] seg;
  logic       in_kcached;
  logic       in_kuncached;
  logic       is_store;

  assign misaligned   = |(lk_vaddr[3:0] & (lk_size - 4'd1));
  assign seg          = lk_vaddr[VA_W-1 -: 3];
  assign in_kcached   = seg == 3'b100;
  assign in_kuncached = seg == 3'b101;
  assign is_store     = acc_e'(lk_kind) == ACC_STORE;

  flt_e            nxt_flt;
  logic [PA_W-1:0] nxt_pa;

  always_comb begin
    nxt_flt = FLT_NONE;
    nxt_pa  = '0;
    if (misaligned) begin
      nxt_flt = FLT_ADDR;
    end else if (in_kcached) begin
      if (priv != PRIV_KERNEL) nxt_flt = FLT_ADDR;
      else                     nxt_pa  = pa_direct;
    end else if (in_kuncached) begin
      nxt_pa = pa_direct;
    end else if (!lk_found) begin
      nxt_flt = FLT_REFILL;
    end else if (!sel_v) begin
      nxt_flt = FLT_INVALID;
    end else if (is_store && !sel_d) begin
      nxt_flt = FLT_MODIFIED;
    end else begin
      nxt_pa = pa_mapped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid    <= 1'b0;
      rs_paddr    <= '0;
      rs_uncached <= 1'b0;
      rs_fault    <= FLT_NONE;
      rs_write    <= 1'b0;
      pr_done     <= 1'b0;
      pr_hit      <= 1'b0;
      pr_index    <= '0;
    end else begin
      rs_valid <= lk_valid;
      pr_done  <= pr_en;
      if (lk_valid) begin
        rs_paddr    <= nxt_pa;
        rs_uncached <= lk_vaddr[VA_W-1] & lk_vaddr[VA_W-3];
        rs_fault    <= nxt_flt;
        rs_write    <= is_store;
      end
      if (pr_en) begin
        pr_hit   <= pb_found;
        pr_index <= pb_idx;
      end
    end
  end

  // R11: flush empties slots and rewinds the pointer
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0) && (victim_idx == '0));
  // R10: write beyond the slot count leaves occupancy alone
  p_oob_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && !(wr_index < N_W)) |=> $stable(occ));
  // R6: misalignment always reports an address error
  p_misalign_first_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (|(lk_vaddr[3:0] & (lk_size - 4'd1))))
      |=> rs_valid && rs_fault == FLT_ADDR);
  // R7: the uncached kernel window never faults when aligned
  p_kseg_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_vaddr[VA_W-1 -: 3] == 3'b101 && !(|(lk_vaddr[3:0] & (lk_size - 4'd1))))
      |=> rs_fault == FLT_NONE && rs_uncached);
  // R5: a modified fault only ever comes from a store
  p_modified_store_r5: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_fault == FLT_MODIFIED) |-> rs_write);
  // R13: one result per request, one cycle later
  p_result_timing_r13: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);
  p_no_spurious_r13: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);
endmodule

// File: tb/paired_tlb_tb.sv
module paired_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [3:0]  lk_size = 4'd1;
  logic [1:0]  lk_kind = '0;
  logic [31:0] lk_status = '0;
  logic        small_pages = 1'b0;
  logic        rs_valid;
  logic [31:0] rs_paddr;
  logic        rs_uncached;
  logic [2:0]  rs_fault;
  logic        rs_write;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_index = '0;
  logic [20:0] wr_vpn = '0;
  logic [20:0] wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn_even = '0;
  logic        wr_valid_even = 1'b0;
  logic        wr_dirty_even = 1'b0;
  logic [19:0] wr_pfn_odd = '0;
  logic        wr_valid_odd = 1'b0;
  logic        wr_dirty_odd = 1'b0;
  logic        pr_en = 1'b0;
  logic [20:0] pr_vpn = '0;
  logic [7:0]  pr_asid = '0;
  logic        pr_done;
  logic        pr_hit;
  logic [3:0]  pr_index;
  logic        flush = 1'b0;
  logic        victim_adv = 1'b0;
  logic [3:0]  victim_idx;

  paired_tlb dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_size(lk_size), .lk_kind(lk_kind), .lk_status(lk_status), .small_pages(small_pages),
    .rs_valid(rs_valid), .rs_paddr(rs_paddr), .rs_uncached(rs_uncached), .rs_fault(rs_fault),
    .rs_write(rs_write), .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn_even(wr_pfn_even),
    .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd), .pr_en(pr_en), .pr_vpn(pr_vpn),
    .pr_asid(pr_asid), .pr_done(pr_done), .pr_hit(pr_hit), .pr_index(pr_index),
    .flush(flush), .victim_adv(victim_adv), .victim_idx(victim_idx));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench-side copy of the programmed slots
  bit          s_occ  [NE];
  logic [20:0] s_vpn  [NE];
  logic [20:0] s_mask [NE];
  logic [7:0]  s_asid [NE];
  bit          s_g    [NE];
  logic [19:0] s_pfn0 [NE];
  logic [19:0] s_pfn1 [NE];
  bit          s_v0 [NE], s_v1 [NE], s_d0 [NE], s_d1 [NE];

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [20:0] vpn, input logic [20:0] mask,
                             input logic [7:0] asid, input bit g,
                             input logic [19:0] p0, input bit v0, input bit d0,
                             input logic [19:0] p1, input bit v1, input bit d1);
    @(negedge clk);
    wr_en = 1'b1; wr_index = 5'(idx); wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
    wr_global = g; wr_pfn_even = p0; wr_valid_even = v0; wr_dirty_even = d0;
    wr_pfn_odd = p1; wr_valid_odd = v1; wr_dirty_odd = d1;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < NE) begin
      s_occ[idx] = 1'b1; s_vpn[idx] = vpn; s_mask[idx] = mask; s_asid[idx] = asid;
      s_g[idx] = g; s_pfn0[idx] = p0; s_v0[idx] = v0; s_d0[idx] = d0;
      s_pfn1[idx] = p1; s_v1[idx] = v1; s_d1[idx] = d1;
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [3:0] sz,
                        input logic [1:0] kind, input logic [31:0] st, input bit sp);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_size = sz; lk_kind = kind;
    lk_status = st; small_pages = sp;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic probe(input logic [20:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    pr_en = 1'b1; pr_vpn = vpn; pr_asid = asid;
    @(negedge clk);
    pr_en = 1'b0;
  endtask

  // arithmetic model of the translation rules
  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic [3:0] sz,
                       input logic [1:0] kind, input logic [31:0] st, input bit sp,
                       output logic [31:0] pa, output logic [2:0] flt, output string tag);
    bit kern;
    logic [20:0] q;
    int hit_i;
    int sh;
    bit odd, v, d;
    longint pfn, base;
    pa = 0; flt = 0; tag = "R4";
    kern = ((st & 32'h1000_0006) != 0) || (((st >> 3) & 3) == 0);
    if ((va & (32'(sz) - 1)) != 0) begin
      flt = 1; tag = "R6";
    end else if (va[31:29] == 3'b100) begin
      tag = "R8";
      if (!kern) flt = 1;
      else pa = va & 32'h1FFF_FFFF;
    end else if (va[31:29] == 3'b101) begin
      tag = "R7";
      pa = va & 32'h1FFF_FFFF;
    end else begin
      q = va[31:11];
      if (!sp) q = q & ~21'h3;
      hit_i = -1;
      for (int i = NE - 1; i >= 0; i--)
        if (s_occ[i] && (((q ^ s_vpn[i]) & ~s_mask[i]) == 0) && (s_g[i] || s_asid[i] == asid))
          hit_i = i;
      if (hit_i < 0) begin
        flt = 2; tag = "R5";
      end else begin
        sh = 10;
        for (int b = 0; b < 21; b++) sh += int'(s_mask[hit_i][b]);
        odd = va[sh];
        v   = odd ? s_v1[hit_i] : s_v0[hit_i];
        d   = odd ? s_d1[hit_i] : s_d0[hit_i];
        pfn = odd ? longint'(s_pfn1[hit_i]) : longint'(s_pfn0[hit_i]);
        if (!v) begin
          flt = 3; tag = "R5";
        end else if (kind == 2 && !d) begin
          flt = 4; tag = "R5";
        end else begin
          base = ((pfn * 4096) >> sh) << sh;
          pa = 32'(base) | (va & ((32'd1 << sh) - 1));
        end
      end
    end
  endtask

  task automatic check_lookup(input logic [31:0] va, input logic [7:0] asid,
                              input logic [3:0] sz, input logic [1:0] kind,
                              input logic [31:0] st, input bit sp);
    logic [31:0] epa;
    logic [2:0]  ef;
    string       tag;
    lookup(va, asid, sz, kind, st, sp);
    model(va, asid, sz, kind, st, sp, epa, ef, tag);
    chk("R13", "rs_valid", rs_valid, 1);
    chk(tag, "fault", rs_fault, ef);
    chk(tag, "paddr", rs_paddr, epa);
    chk("R9", "uncached", rs_uncached, va[31] & va[29]);
    chk("R5", "write flag", rs_write, kind == 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic [31:0] vas [20] = '{
    32'h0040_0000, 32'h0040_0ffc, 32'h0040_1000, 32'h0040_1002, 32'h0040_1001,
    32'h0100_0000, 32'h0100_3ff0, 32'h0100_4000, 32'h0100_7ffc, 32'h0080_0800,
    32'h0080_0c00, 32'h0080_0bfc, 32'h0060_0000, 32'h00A0_0000, 32'h8000_1234,
    32'h9fff_fffc, 32'ha000_0010, 32'hbfff_fff0, 32'he000_0000, 32'h0040_2000};
  logic [31:0] sts [7] = '{32'h0, 32'h10, 32'h08, 32'h12, 32'h1000_0010, 32'h18, 32'h14};
  logic [3:0]  szs [3] = '{4'd1, 4'd2, 4'd4};

  initial begin
    for (int i = 0; i < NE; i++) s_occ[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk("R13", "reset rs_valid", rs_valid, 0);
    chk("R13", "reset rs_fault", rs_fault, 0);
    chk("R13", "reset pr_done", pr_done, 0);
    chk("R13", "reset victim", victim_idx, 0);

    write_entry(0, 21'h800, 21'h3, 8'd5, 0, 20'h111, 1, 1, 20'h222, 1, 0);
    write_entry(1, 21'h2000, 21'hF, 8'd9, 1, 20'h345, 1, 1, 20'h456, 0, 0);
    write_entry(2, 21'h1001, 21'h0, 8'd5, 0, 20'h50, 1, 1, 20'h60, 1, 1);
    write_entry(3, 21'h800, 21'h3, 8'd5, 0, 20'h777, 1, 1, 20'h778, 1, 1);
    write_entry(5, 21'h1400, 21'h3, 8'd7, 0, 20'h88, 1, 1, 20'h89, 1, 1);
    write_entry(16, 21'hC00, 21'h3, 8'd5, 0, 20'h99, 1, 1, 20'h9A, 1, 1);

    // R1 lowest slot wins over the duplicate in slot 3
    lookup(32'h0040_0010, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R1", "lowest slot paddr", rs_paddr, 32'h0011_1010);
    lookup(32'h0040_0010, 8'd6, 4'd4, 2'd1, 32'h0, 0);
    chk("R1", "identifier mismatch refill", rs_fault, 2);
    lookup(32'h0100_0000, 8'd6, 4'd4, 2'd1, 32'h0, 0);
    chk("R1", "global slot paddr", rs_paddr, 32'h0034_4000);
    // R3 odd half and its dirty bit
    lookup(32'h0040_1000, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R3", "odd frame paddr", rs_paddr, 32'h0022_2000);
    lookup(32'h0040_1000, 8'd5, 4'd4, 2'd2, 32'h0, 0);
    chk("R5", "store to clean half", rs_fault, 4);
    // R4 frame truncation under a 16 KB page
    lookup(32'h0100_3ff0, 8'd1, 4'd4, 2'd0, 32'h0, 0);
    chk("R4", "large page paddr", rs_paddr, 32'h0034_7ff0);
    lookup(32'h0100_4000, 8'd1, 4'd4, 2'd0, 32'h0, 0);
    chk("R5", "invalid odd half", rs_fault, 3);
    // R2 small page mode
    lookup(32'h0080_0c00, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R2", "small slot without mode", rs_fault, 2);
    lookup(32'h0080_0c00, 8'd5, 4'd4, 2'd1, 32'h0, 1);
    chk("R2", "small slot odd half", rs_paddr, 32'h0006_0000);
    // R10 ignored write, then a write seen next cycle
    lookup(32'h0060_0000, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R10", "out-of-range write ignored", rs_fault, 2);
    write_entry(6, 21'hC00, 21'h3, 8'd5, 0, 20'h99, 1, 1, 20'h9A, 1, 1);
    lookup(32'h0060_0000, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R10", "fresh write visible", rs_paddr, 32'h0009_9000);

    // sweep against the model (R6 R7 R8 R9 and the rest)
    for (int a = 0; a < 20; a++)
      for (int s = 0; s < 7; s++)
        for (int z = 0; z < 3; z++)
          for (int k = 0; k < 3; k++)
            for (int m = 0; m < 2; m++)
              check_lookup(vas[a], (m == 0) ? 8'd5 : 8'd7, szs[z], 2'(k), sts[s], (a % 2) == 1);

    // R12 probe
    probe(21'h800, 8'd5);
    chk("R12", "probe done", pr_done, 1);
    chk("R12", "probe hit", pr_hit, 1);
    chk("R12", "probe index", pr_index, 0);
    probe(21'h800, 8'd6);
    chk("R12", "probe miss", pr_hit, 0);
    probe(21'h2003, 8'd42);
    chk("R12", "probe masked global hit", pr_hit, 1);
    chk("R12", "probe masked global index", pr_index, 1);
    probe(21'h1400, 8'd7);
    chk("R12", "probe slot 5 index", pr_index, 5);

    // R11 pointer wrap and flush
    @(negedge clk);
    victim_adv = 1'b1;
    repeat (17) @(negedge clk);
    victim_adv = 1'b0;
    chk("R11", "victim wraps", victim_idx, 1);
    @(negedge clk);
    flush = 1'b1; victim_adv = 1'b1;
    @(negedge clk);
    flush = 1'b0; victim_adv = 1'b0;
    for (int i = 0; i < NE; i++) s_occ[i] = 1'b0;
    chk("R11", "victim after flush", victim_idx, 0);
    lookup(32'h0040_0010, 8'd5, 4'd4, 2'd1, 32'h0, 0);
    chk("R11", "refill after flush", rs_fault, 2);
    probe(21'h2000, 8'd9);
    chk("R11", "probe after flush", pr_hit, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule